// File: doc/BRIEF.md
# I2C SCL Count Calculator

This block turns I2C bus timing targets into the three counts a bus controller needs: SCL high count, SCL low count and SDA hold count. These counts are expressed in controller clock cycles. The inputs are a speed mode, the controller clock as a ticks-per-nanoseconds ratio, the board rise and fall times, two spike-suppression lengths and an optional SDA hold time. On a start pulse the block captures every input. It then runs six ceiling divisions in sequence on one shift-subtract divider. From the results it back-solves the counts, using the controller's SCL equations, which include the spike length and a fixed overhead of 7 cycles. Finally it pads the counts so that one SCL period reaches the bus period.

Firmware or a boot sequencer uses the block once per speed mode. It pulses start, waits for done and then copies the counts into the controller's timing registers.

Top module: `scl_count_calc`

## Requirements
- R1: After reset, busy, done and err are 0 and hcnt, lcnt and sda_hold are 0.
- R2: The block accepts a start pulse only while busy is 0. It then holds busy at 1. Done is 1 for exactly one cycle, 6*DW+1 clock edges after the accepting edge, and busy falls on that same edge.
- R3: Start and every other input are ignored while busy is 1. A second start during a run neither restarts the run nor changes its results or its timing.
- R4: Each time is converted to a count as ceil(clk_ticks*time_ns/clk_ns). The mode encoding is 0 standard, 1 fast, 2 fast-plus, 3 high. The minimum high/low times are 4000/4700, 600/1300, 260/500 and 60/160 ns.
- R5: The period count is ceil(clk_ticks*bus_ns/(clk_ns*bus_ticks)). The bus rates are 100 kHz, 400 kHz, 1 MHz and 3.4 MHz for modes 0 to 3.
- R6: hcnt = thigh_cnt - fall_cnt - 7 - spk, and lcnt = tlow_cnt - rise_cnt + fall_cnt - 1.
- R7: Mode 3 takes spk from spk_high. Modes 0 to 2 take spk from spk_fast.
- R8: Let total = hcnt+lcnt+7+spk+rise_cnt+1. When total is below the period count, half the shortfall (rounded down) is added to both counts, and the rest of the shortfall is added to lcnt.
- R9: If either back-solved count is negative, err is 1 with done, and hcnt, lcnt and sda_hold are 0.
- R10: A hold_ns of 0 selects 300 ns. The hold time is converted with the ceiling rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (taken only while idle) |
| mode | input | 2 | Speed mode: 0 standard, 1 fast, 2 fast-plus, 3 high |
| clk_ticks | input | TW | Controller clock ticks per clk_ns nanoseconds |
| clk_ns | input | TW | Nanoseconds that clk_ticks spans |
| rise_ns | input | NW | Board SCL rise time |
| fall_ns | input | NW | Board SCL fall time |
| spk_fast | input | SPW | Spike length for modes 0 to 2 |
| spk_high | input | SPW | Spike length for mode 3 |
| hold_ns | input | NW | SDA hold time, 0 selects 300 ns |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Counts came out negative |
| hcnt | output | DW | SCL high count |
| lcnt | output | DW | SCL low count |
| sda_hold | output | DW | SDA hold count |

## Verification
The bench runs both a 120/1000 clock and a 400/3000 clock through all four modes. This separates the per-mode time and bus-rate tables and shows the ceiling effect of a non-integer ratio. With small rise and fall times, the high-speed runs split two cases: fall times large enough to make hcnt negative, which must give an error, and small spike lengths that give real counts. Giving the two spike inputs different values shows which one each mode reads. Runs with and without a hold time exercise the default hold value. A start pulse injected in the middle of a run, carrying a different mode, shows that inputs are captured at the start and that a run cannot restart.

// File: rtl/scl_count_calc.sv
module scl_count_calc #(
  parameter int TW  = 12,
  parameter int NW  = 16,
  parameter int SPW = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode,
  input  logic [TW-1:0]  clk_ticks,
  input  logic [TW-1:0]  clk_ns,
  input  logic [NW-1:0]  rise_ns,
  input  logic [NW-1:0]  fall_ns,
  input  logic [SPW-1:0] spk_fast,
  input  logic [SPW-1:0] spk_high,
  input  logic [NW-1:0]  hold_ns,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [DW-1:0]  hcnt,
  output logic [DW-1:0]  lcnt,
  output logic [DW-1:0]  sda_hold
);
  localparam int NDIV = 6;
  localparam int CW = $clog2(DW);
  localparam int SW = DW + 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [1:0]     c_mode;
  logic [TW-1:0]  c_ticks, c_ns;
  logic [NW-1:0]  c_rise, c_fall, c_hold;
  logic [SPW-1:0] c_spk;
  logic [2:0]     idx;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  rem, quo;
  logic [DW-1:0]  res [NDIV];

  logic [DW-1:0] tgt_ns, num, den, bus_ns, bus_tk, tlow_ns, thigh_ns;
  logic [DW-1:0] num_nx, den_nx;

  always_comb begin
    case (c_mode)
      2'd0: begin bus_tk = DW'(100);  tlow_ns = DW'(4700); thigh_ns = DW'(4000); end
      2'd1: begin bus_tk = DW'(400);  tlow_ns = DW'(1300); thigh_ns = DW'(600);  end
      2'd2: begin bus_tk = DW'(1);    tlow_ns = DW'(500);  thigh_ns = DW'(260);  end
      default: begin bus_tk = DW'(3400); tlow_ns = DW'(160); thigh_ns = DW'(60); end
    endcase
    bus_ns = (c_mode == 2'd2) ? DW'(1000) : DW'(1000000);
  end

  function automatic logic [DW-1:0] pick_ns(input logic [2:0] k, input logic [DW-1:0] tl,
                                            input logic [DW-1:0] th, input logic [NW-1:0] r,
                                            input logic [NW-1:0] f, input logic [NW-1:0] h);
    case (k)
      3'd1: pick_ns = DW'(r);
      3'd2: pick_ns = DW'(f);
      3'd3: pick_ns = tl;
      3'd4: pick_ns = th;
      default: pick_ns = (h == '0) ? DW'(300) : DW'(h);
    endcase
  endfunction

  assign tgt_ns = pick_ns(idx + 3'd1, tlow_ns, thigh_ns, c_rise, c_fall, c_hold);
  assign num_nx = DW'(c_ticks) * tgt_ns;
  assign den_nx = DW'(c_ns);
  assign num    = DW'(c_ticks) * bus_ns;
  assign den    = DW'(c_ns) * bus_tk;

  logic [DW:0]   shl;
  logic [DW+1:0] trial;
  logic          ge;
  logic [DW-1:0] rem_n, quo_n, ceil_q, den_cur;

  assign den_cur = (idx == 3'd0) ? den : den_nx;
  assign shl     = {rem, quo[DW-1]};
  assign trial   = {1'b0, shl} - {2'b00, den_cur};
  assign ge      = ~trial[DW+1];
  assign rem_n   = ge ? trial[DW-1:0] : shl[DW-1:0];
  assign quo_n   = {quo[DW-2:0], ge};
  assign ceil_q  = quo_n + DW'(rem_n != '0);

  logic signed [SW-1:0] pe, ri, fa, tl, th, sp, hc0, lc0, tot0, gap, half, hc, lc;
  assign pe   = $signed({3'b000, res[0]});
  assign ri   = $signed({3'b000, res[1]});
  assign fa   = $signed({3'b000, res[2]});
  assign tl   = $signed({3'b000, res[3]});
  assign th   = $signed({3'b000, res[4]});
  assign sp   = $signed(SW'(c_spk));
  assign hc0  = th - fa - SW'(7) - sp;
  assign lc0  = tl - ri + fa - SW'(1);
  assign tot0 = hc0 + lc0 + SW'(7) + sp + ri + SW'(1);
  assign gap  = pe - tot0;
  assign half = gap >>> 1;
  assign hc   = (gap > 0) ? hc0 + half : hc0;
  assign lc   = (gap > 0) ? lc0 + gap - half : lc0;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; cnt <= '0; rem <= '0; quo <= '0;
      c_mode <= '0; c_ticks <= '0; c_ns <= '0; c_rise <= '0; c_fall <= '0;
      c_hold <= '0; c_spk <= '0;
      for (int i = 0; i < NDIV; i++) res[i] <= '0;
      done <= 1'b0; err <= 1'b0; hcnt <= '0; lcnt <= '0; sda_hold <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; idx <= '0; cnt <= '0; rem <= '0;
          c_mode <= mode; c_ticks <= clk_ticks; c_ns <= clk_ns;
          c_rise <= rise_ns; c_fall <= fall_ns; c_hold <= hold_ns;
          c_spk <= (mode == 2'd3) ? spk_high : spk_fast;
          quo <= DW'(clk_ticks) * ((mode == 2'd2) ? DW'(1000) : DW'(1000000));
        end
        S_RUN: begin
          if (cnt == CW'(DW - 1)) begin
            res[idx] <= ceil_q;
            cnt <= '0; rem <= '0;
            quo <= num_nx;
            if (idx == 3'(NDIV - 1)) st <= S_FIN;
            else idx <= idx + 3'd1;
          end else begin
            cnt <= cnt + CW'(1);
            rem <= rem_n;
            quo <= quo_n;
          end
        end
        default: begin
          st <= S_IDLE;
          done <= 1'b1;
          if (hc0 < 0 || lc0 < 0) begin
            err <= 1'b1; hcnt <= '0; lcnt <= '0; sda_hold <= '0;
          end else begin
            err <= 1'b0; hcnt <= hc[DW-1:0]; lcnt <= lc[DW-1:0]; sda_hold <= res[5];
          end
        end
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^num;
endmodule

// File: rtl/scl_count_calc_chk.sv
module scl_count_calc_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] hcnt,
  input logic [DW-1:0] lcnt,
  input logic [DW-1:0] sda_hold
);
  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r3_outputs_hold_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hcnt) && $stable(lcnt) && $stable(sda_hold) && !done));
  a_r9_error_clears_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (hcnt == '0 && lcnt == '0 && sda_hold == '0));
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !err));
endmodule

bind scl_count_calc scl_count_calc_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .hcnt(hcnt), .lcnt(lcnt), .sda_hold(sda_hold)
);

// File: tb/scl_count_calc_tb.sv
module scl_count_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int LAT = 6 * DW + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [11:0] clk_ticks = '0, clk_ns = '0;
  logic [15:0] rise_ns = '0, fall_ns = '0, hold_ns = '0;
  logic [7:0] spk_fast = '0, spk_high = '0;
  logic busy, done, err;
  logic [DW-1:0] hcnt, lcnt, sda_hold;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_count_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .clk_ticks(clk_ticks),
    .clk_ns(clk_ns), .rise_ns(rise_ns), .fall_ns(fall_ns), .spk_fast(spk_fast),
    .spk_high(spk_high), .hold_ns(hold_ns), .busy(busy), .done(done), .err(err),
    .hcnt(hcnt), .lcnt(lcnt), .sda_hold(sda_hold)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  task automatic model(input int m, input longint t, input longint n, input longint r,
                       input longint f, input longint spk, input longint h,
                       output longint eh, output longint el, output longint es, output bit ee);
    longint lo_t[4] = '{4700, 1300, 500, 160};
    longint hi_t[4] = '{4000, 600, 260, 60};
    longint btk[4]  = '{100, 400, 1, 3400};
    longint bns[4]  = '{1000000, 1000000, 1000, 1000000};
    longint per, rc, fc, tlc, thc, hh, ll, tot, d;
    per = cdiv(t * bns[m], n * btk[m]);
    rc  = cdiv(t * r, n);
    fc  = cdiv(t * f, n);
    tlc = cdiv(t * lo_t[m], n);
    thc = cdiv(t * hi_t[m], n);
    hh  = thc - fc - 7 - spk;
    ll  = tlc - rc + fc - 1;
    ee  = (hh < 0) || (ll < 0);
    tot = hh + ll + 7 + spk + rc + 1;
    if (tot < per) begin
      d = (per - tot) / 2;
      hh += d; ll += d;
      tot = hh + ll + 7 + spk + rc + 1;
      ll += per - tot;
    end
    es = cdiv(t * ((h == 0) ? 300 : h), n);
    if (ee) begin hh = 0; ll = 0; es = 0; end
    eh = hh; el = ll;
  endtask

  task automatic run(input int m, input int t, input int n, input int r, input int f,
                     input int sf, input int sh, input int h, input bit poke, input string tag);
    longint eh, el, es; bit ee;
    model(m, t, n, r, f, (m == 3) ? sh : sf, h, eh, el, es, ee);
    @(negedge clk);
    mode = 2'(m); clk_ticks = 12'(t); clk_ns = 12'(n); rise_ns = 16'(r); fall_ns = 16'(f);
    spk_fast = 8'(sf); spk_high = 8'(sh); hold_ns = 16'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R2 busy after start ", tag}, longint'(busy), 1);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done == (k == LAT), {"R2 done timing ", tag}, longint'(done), longint'(k == LAT));
      chk(busy == (k < LAT), {"R2 busy timing ", tag}, longint'(busy), longint'(k < LAT));
      if (k == LAT) begin
        chk(err == ee, {"R9 err ", tag}, longint'(err), longint'(ee));
        chk(longint'(hcnt) == eh, {"R6 R7 R8 hcnt ", tag}, longint'(hcnt), eh);
        chk(longint'(lcnt) == el, {"R4 R5 R8 lcnt ", tag}, longint'(lcnt), el);
        chk(longint'(sda_hold) == es, {"R10 sda_hold ", tag}, longint'(sda_hold), es);
      end
      if (poke && k == 40) begin
        start = 1'b1; mode = ~mode; hold_ns = 16'd999; spk_fast = 8'd0; spk_high = 8'd0;
      end
    end
    @(negedge clk);
    chk(done == 1'b0, {"R2 done drops ", tag}, longint'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1 reset flags", longint'({busy, done, err}), 0);
    chk(hcnt == '0 && lcnt == '0 && sda_hold == '0, "R1 reset counts", longint'(hcnt), 0);
    rst_n = 1'b1;
    // R4 R5: both clocks across all modes, small edges
    for (int m = 0; m < 4; m++) begin
      run(m, 120, 1000, 10, 0, 5, 0, 0, 1'b0, "120MHz");
      run(m, 400, 3000, 10, 0, 5, 0, 0, 1'b0, "133MHz");
    end
    // R9: high-speed with a large fall time goes negative
    run(3, 120, 1000, 100, 30, 5, 1, 0, 1'b0, "R9 hs negative");
    run(3, 400, 3000, 100, 30, 5, 1, 0, 1'b0, "R9 hs negative 133");
    // R8 R6: typical board edges, padding active
    run(0, 120, 1000, 100, 30, 5, 1, 0, 1'b0, "R8 std pad");
    run(1, 400, 3000, 120, 40, 3, 1, 0, 1'b0, "R8 fast pad");
    // R7: spike inputs differ, mode 3 reads spk_high, mode 2 reads spk_fast
    run(3, 120, 1000, 10, 0, 9, 1, 0, 1'b0, "R7 hs spike");
    run(2, 120, 1000, 10, 0, 9, 1, 0, 1'b0, "R7 fp spike");
    // R10: supplied hold time
    run(1, 120, 1000, 100, 30, 5, 1, 500, 1'b0, "R10 hold 500");
    run(0, 400, 3000, 100, 30, 5, 1, 77, 1'b0, "R10 hold 77");
    // R3: start pulse with other inputs in the middle of a run
    run(1, 120, 1000, 100, 30, 5, 1, 0, 1'b1, "R3 poke");
    run(3, 400, 3000, 10, 0, 5, 0, 200, 1'b1, "R3 poke hs");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule